// File: doc/BRIEF.md
# Even-Word Block Readout Padder

This block sits on the read side of an event buffer and feeds 32-bit event words (header, data, end-of-block) onto a bus slave's block-transfer data path. While a transfer is active it pulls words from the buffer one per cycle. When the buffer has no more words for this transfer, it ends the transfer with a one-cycle bus-error request. Some bridges move data in 64-bit units and drop a trailing odd 32-bit word. For them, the block can make each transfer end on an even word count by inserting one tagged filler word ahead of the bus error.

Padding depends on three things: a configuration bit that resets to off, the width of the transfer, and the board's position in a chained transfer. Only a standalone board or the last board in a chain pads. The filler never consumes a buffer entry, so the next event's header stays queued. In block-end mode a transfer stops after one event's end-of-block word. Outside a transfer, single reads still return every word, including that end-of-block word.

Top module: `even_word_padder`

## Requirements
- R1: After reset the alignment bit is 0. An odd-length single-board 32-bit transfer then delivers exactly its own word count, with no filler.
- R2: With alignment on, a single-board 32-bit transfer delivers an even number of words. It appends one filler word only when the event's word count is odd.
- R3: In a chained transfer (`chained`=1), a board with `lastInChain`=0 never emits a filler word. The last board pads by the same rule as a single board.
- R4: In a 64-bit transfer (`wide64`=1), a standalone or last board with an odd word count always appends the filler word `{3'b110, 29'd0}`, whatever the alignment bit. The type field is bits [31:29]: 010 header, 000 data, 100 end-of-block, 110 filler.
- R5: Emitting the filler does not pop the buffer, so the following event's header is still the next buffer word.
- R6: The bus-error request is high for exactly one cycle, in the cycle right after the last delivered word. No word is delivered after it within the transfer.
- R7: The word-parity state clears when a new transfer starts. An earlier transfer that ended on an odd count does not change the padding of the next one.
- R8: With `blkEndEn`=1, a transfer ends after the first end-of-block word it delivers. With `xferActive`=0, a one-cycle `singleRd` pulse returns the next buffer word, including an end-of-block word, with `outValid` and no bus error.
- R9: Buffer words are delivered unmodified and in buffer order. Each word appears one cycle after it is popped.
- R10: A cycle with `cfgWe`=1 loads `cfgAlign` into the alignment bit, and that value applies to later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for the alignment bit |
| cfgAlign | input | 1 | Alignment bit value to write |
| blkEndEn | input | 1 | Block-end mode: stop the transfer after one end-of-block word |
| xferActive | input | 1 | High for the duration of a block transfer |
| singleRd | input | 1 | Single-read request, used while no transfer is active |
| chained | input | 1 | The transfer is a chained multi-board transfer |
| lastInChain | input | 1 | This board is last in the chain |
| wide64 | input | 1 | The transfer moves 64-bit units |
| bufWord | input | 32 | Word at the head of the event buffer |
| bufEmpty | input | 1 | The event buffer holds no word |
| bufPop | output | 1 | Consume the head buffer word |
| outData | output | 32 | Word presented to the bus |
| outValid | output | 1 | `outData` holds a word this cycle |
| busErrReq | output | 1 | One-cycle request to end the transfer with a bus error |

## Verification
The bench sweeps event lengths from two to seven words. For each length it runs every combination of the alignment bit, chain mode, chain position, transfer width and block-end mode, then compares word count, content and filler placement with arithmetic expectations. A design that pads intermediate chain boards or pads even counts would put a surplus filler at the end. A design that pops the buffer on the filler would swallow the next event's header, and the bench reads the buffer position after block-end transfers to catch that. Back-to-back transfers where the first ends on an odd count expose parity that is not cleared. Single reads with block-end mode on check that the end-of-block word is still reachable. The bench also checks the timing of the bus-error pulse against the last delivered word.

// File: rtl/padder_pkg.sv
package padder_pkg;
  localparam int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    WT_DATA = 3'b000,
    WT_HEAD = 3'b010,
    WT_EOB  = 3'b100,
    WT_FILL = 3'b110
  } wordType_t;

  typedef struct packed {
    logic emitBuf;   // present buffer head word and pop it
    logic emitFill;  // present the filler word, no pop
    logic inXfer;    // emission belongs to a block transfer
    logic clrXfer;   // new transfer starts: clear parity and block-end flag
    logic raiseErr;  // request the ending bus error
  } strobes_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_STREAM,
    S_BERR,
    S_DONE
  } state_t;
endpackage

// File: rtl/padder_datapath.sv
module padder_datapath
  import padder_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgAlign,
  input  logic              blkEndEn,
  input  logic [WORD_W-1:0] bufWord,
  input  strobes_t          stb,
  output logic              oddWords,
  output logic              eobSeen,
  output logic              alignOn,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic              busErrReq
);
  localparam logic [WORD_W-1:0] FILL_WORD = {WT_FILL, {(WORD_W-TYPE_W){1'b0}}};

  logic [TYPE_W-1:0] headType;
  logic              isEob;

  assign headType = bufWord[WORD_W-1 -: TYPE_W];
  assign isEob    = (headType == WT_EOB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alignOn   <= 1'b0;
      outData   <= '0;
      outValid  <= 1'b0;
      busErrReq <= 1'b0;
      oddWords  <= 1'b0;
      eobSeen   <= 1'b0;
    end else begin
      if (cfgWe) alignOn <= cfgAlign;
      outValid  <= stb.emitBuf | stb.emitFill;
      busErrReq <= stb.raiseErr;
      if (stb.emitBuf)       outData <= bufWord;
      else if (stb.emitFill) outData <= FILL_WORD;
      if (stb.clrXfer) begin
        oddWords <= 1'b0;
        eobSeen  <= 1'b0;
      end else if (stb.inXfer) begin
        if (stb.emitBuf | stb.emitFill) oddWords <= ~oddWords;
        if (stb.emitBuf && blkEndEn && isEob) eobSeen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/padder_ctrl.sv
module padder_ctrl
  import padder_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     xferActive,
  input  logic     singleRd,
  input  logic     chained,
  input  logic     lastInChain,
  input  logic     wide64,
  input  logic     bufEmpty,
  input  logic     oddWords,
  input  logic     eobSeen,
  input  logic     alignOn,
  output strobes_t stb,
  output logic     bufPop
);
  state_t state, nextState;
  logic   padNeed;
  logic   mayPad;

  assign mayPad  = !chained || lastInChain;
  assign padNeed = oddWords && mayPad && (alignOn || wide64);

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (xferActive) begin
          stb.clrXfer = 1'b1;
          nextState   = S_STREAM;
        end else if (singleRd && !bufEmpty) begin
          stb.emitBuf = 1'b1;
        end
      end
      S_STREAM: begin
        if (!xferActive) begin
          nextState = S_IDLE;
        end else if (bufEmpty || eobSeen) begin
          if (padNeed) begin
            stb.emitFill = 1'b1;
            stb.inXfer   = 1'b1;
            nextState    = S_BERR;
          end else begin
            stb.raiseErr = 1'b1;
            nextState    = S_DONE;
          end
        end else begin
          stb.emitBuf = 1'b1;
          stb.inXfer  = 1'b1;
        end
      end
      S_BERR: begin
        stb.raiseErr = 1'b1;
        nextState    = S_DONE;
      end
      default: begin
        if (!xferActive) nextState = S_IDLE;
      end
    endcase
  end

  assign bufPop = stb.emitBuf;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/even_word_padder.sv
module even_word_padder
  import padder_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgAlign,
  input  logic              blkEndEn,
  input  logic              xferActive,
  input  logic              singleRd,
  input  logic              chained,
  input  logic              lastInChain,
  input  logic              wide64,
  input  logic [WORD_W-1:0] bufWord,
  input  logic              bufEmpty,
  output logic              bufPop,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic              busErrReq
);
  strobes_t stb;
  logic     oddWords;
  logic     eobSeen;
  logic     alignOn;

  padder_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .xferActive (xferActive),
    .singleRd   (singleRd),
    .chained    (chained),
    .lastInChain(lastInChain),
    .wide64     (wide64),
    .bufEmpty   (bufEmpty),
    .oddWords   (oddWords),
    .eobSeen    (eobSeen),
    .alignOn    (alignOn),
    .stb        (stb),
    .bufPop     (bufPop)
  );

  padder_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAlign (cfgAlign),
    .blkEndEn (blkEndEn),
    .bufWord  (bufWord),
    .stb      (stb),
    .oddWords (oddWords),
    .eobSeen  (eobSeen),
    .alignOn  (alignOn),
    .outData  (outData),
    .outValid (outValid),
    .busErrReq(busErrReq)
  );
endmodule

// File: rtl/padder_checker.sv
module padder_checker
  import padder_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              xferActive,
  input logic              chained,
  input logic              alignOn,
  input logic              bufPop,
  input logic              bufEmpty,
  input logic [WORD_W-1:0] outData,
  input logic              outValid,
  input logic              busErrReq
);
  logic oddSeen;

  always_ff @(posedge clk) begin
    if (!rstN || !xferActive) oddSeen <= 1'b0;
    else if (outValid)        oddSeen <= ~oddSeen;
  end

  // R6: the bus-error request lasts a single cycle
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    busErrReq |=> !busErrReq);

  // R6: nothing is delivered after the bus-error request
  assert_no_word_after_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    busErrReq |=> !outValid);

  // R2: standalone aligned transfers end on an even count
  assert_even_total_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busErrReq && alignOn && !chained) |-> !oddSeen);

  // R5: a pop only happens when the buffer has data
  assert_pop_has_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufPop |-> !bufEmpty);

  // R5: a popped word is never replaced by the filler
  assert_pop_not_fill_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufPop |=> (outValid && outData[WORD_W-1 -: TYPE_W] != WT_FILL));
endmodule

bind even_word_padder padder_checker #(.WORD_W(WORD_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .xferActive(xferActive),
  .chained   (chained),
  .alignOn   (alignOn),
  .bufPop    (bufPop),
  .bufEmpty  (bufEmpty),
  .outData   (outData),
  .outValid  (outValid),
  .busErrReq (busErrReq)
);

// File: tb/test_even_word_padder.sv
`timescale 1ns/1ps
module test_even_word_padder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgAlign = 1'b0, blkEndEn = 1'b0;
  logic        xferActive = 1'b0, singleRd = 1'b0;
  logic        chained = 1'b0, lastInChain = 1'b0, wide64 = 1'b0;
  logic [31:0] bufWord;
  logic        bufEmpty, bufPop;
  logic [31:0] outData;
  logic        outValid, busErrReq;

  logic [31:0] mem [0:15];
  int          popCnt = 0;
  int          base = 0;
  int          wr = 0;
  int          rdPos;
  int          checks = 0;
  int          errors = 0;
  localparam logic [31:0] FILL = {3'b110, 29'd0};

  always #2.5 clk = ~clk;

  assign rdPos    = popCnt - base;
  assign bufEmpty = (rdPos >= wr);
  assign bufWord  = mem[rdPos[3:0]];

  always @(posedge clk) if (bufPop) popCnt <= popCnt + 1;

  even_word_padder i_even_word_padder (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAlign(cfgAlign),
    .blkEndEn(blkEndEn), .xferActive(xferActive), .singleRd(singleRd),
    .chained(chained), .lastInChain(lastInChain), .wide64(wide64),
    .bufWord(bufWord), .bufEmpty(bufEmpty), .bufPop(bufPop),
    .outData(outData), .outValid(outValid), .busErrReq(busErrReq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic loadEvent(input int n, input int salt, input bit second);
    base = popCnt;
    wr   = 0;
    for (int i = 0; i < n; i++) begin
      if (i == 0)          mem[wr] = {3'b010, 29'(n * 16 + salt)};
      else if (i == n - 1) mem[wr] = {3'b100, 29'(salt)};
      else                 mem[wr] = {3'b000, 29'(i * 7 + salt)};
      wr++;
    end
    if (second) begin
      mem[wr] = {3'b010, 29'h1abc}; wr++;
      mem[wr] = {3'b000, 29'h55};   wr++;
      mem[wr] = {3'b100, 29'h66};   wr++;
    end
  endtask

  task automatic runXfer(input int n, input bit doCfg, input bit al, input bit ch,
                         input bit la, input bit wd, input bit be, input string tagOv);
    int    got = 0, errCnt = 0, lastV = -1, errAt = -1;
    bit    pad;
    string tag;
    loadEvent(n, n + 3, be);
    @(negedge clk);
    if (doCfg) begin
      cfgWe = 1'b1; cfgAlign = al;
      @(negedge clk);
      cfgWe = 1'b0;
    end
    chained = ch; lastInChain = la; wide64 = wd; blkEndEn = be;
    xferActive = 1'b1;
    pad = (n % 2 == 1) && (!ch || la) && (al || wd);
    tag = (tagOv != "") ? tagOv : (wd ? "R4" : (ch ? "R3" : "R2"));
    for (int cyc = 0; cyc < 30; cyc++) begin
      @(negedge clk);
      if (outValid) begin
        logic [31:0] expW;
        expW = (got < n) ? mem[got] : FILL;
        check(outData == expW && errCnt == 0, (got < n) ? "R9" : "R4", outData, expW);
        got++;
        lastV = cyc;
      end
      if (busErrReq) begin
        errCnt++;
        errAt = cyc;
      end
    end
    xferActive = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(got == n + int'(pad), tag, got, n + int'(pad));
    check(errCnt == 1, "R6", errCnt, 1);
    check(errAt == lastV + 1, "R6", errAt, lastV + 1);
    if (be) check(rdPos == n, "R5", rdPos, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && busErrReq == 1'b0 && bufPop == 1'b0, "R1",
          {outValid, busErrReq, bufPop}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: alignment bit starts cleared, no filler on an odd count
    runXfer(3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R10: writing the bit enables padding
    runXfer(5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    // R7: odd intermediate chain transfer then even standalone one
    runXfer(3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    runXfer(4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    // sweep of lengths and configurations
    for (int n = 2; n <= 7; n++)
      for (int cfg = 0; cfg < 32; cfg++)
        runXfer(n, 1'b1, cfg[0], cfg[1], cfg[2], cfg[3], cfg[4], "");
    // R8: single reads reach every word including end-of-block
    loadEvent(3, 9, 1'b0);
    blkEndEn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      singleRd = 1'b1;
      @(negedge clk);
      singleRd = 1'b0;
      check(outValid && outData == mem[i] && !busErrReq, "R8", outData, mem[i]);
    end
    @(negedge clk);
    check(rdPos == 3, "R8", rdPos, 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule